// File: doc/BRIEF.md
# PHY Status Transfer Sender

This block is the PHY-side serializer that reports status to the link layer. Four event flags are collected in a pending set: arbitration reset gap, subaction gap, bus reset and PHY interrupt. A single register read result, a 4-bit address with 8 data bits, can also be held. The block sends these over a 2-bit data lane, two bits per clock, while a 2-bit control bus carries the status code. A transfer that carries only flags takes 2 beats. A transfer that also carries a register result takes 8 beats.

A receive request from the serial side can take over the bus in any cycle. When it does, the sender drops out in that same cycle and the control bus shows the receive code. Flag bits count as delivered in the beat that drives them. A register result counts as delivered only after its last data beat. Once the receive ends, a new transfer is started if anything is still outstanding, and not otherwise.

Top module: `phy_status_tx`

## Requirements
- R1: After reset, `ctl_out` is 2'b00 (idle), `dat_out` is 2'b00, `reg_ready` is 1 and nothing is pending, so the block stays idle.
- R2: With only flags pending, a transfer is exactly 2 beats with `ctl_out` = 2'b01 (status). Beat 0 carries frame bits 0 and 1. Beat 1 carries frame bits 2 and 3.
- R3: With a register result held, a transfer is exactly 8 beats. Frame bits 0..3 are flags 0..3 (0 arbitration reset gap, 1 subaction gap, 2 bus reset, 3 interrupt). Frame bit 4+i is `reg_addr[3-i]`. Frame bit 8+i is `reg_data[7-i]`.
- R4: Beat j carries frame bit 2j on `dat_out[0]` and frame bit 2j+1 on `dat_out[1]`. Beats go out in ascending j.
- R5: An event or register result that is sampled at clock edge n is first seen as beat 0 in the cycle after edge n+1. In the cycle between those two edges, `ctl_out` is still 2'b00.
- R6: After the last beat of a transfer, `ctl_out` is 2'b00 for at least one cycle before the next status beat.
- R7: While `rx_preempt` is 1, `ctl_out` is 2'b10 (receive) and `dat_out` is 2'b00, in the same cycle. The transfer is abandoned. After `rx_preempt` falls, at least one idle cycle comes before any retry.
- R8: A flag bit is removed from the pending set once its beat has been driven, even if that transfer is later pre-empted.
- R9: A register result stays pending until all 8 beats have been driven. After a pre-emption, it is sent again as a full 8-beat transfer.
- R10: After a pre-emption, a new transfer starts only if a flag or the register result is still outstanding. Otherwise `ctl_out` stays 2'b00.
- R11: Flag events that arrive during a transfer are OR-ed into the pending set and sent in the next transfer.
- R12: `reg_ready` is 0 while a register result is held, and 1 from the cycle after its final beat. A result is accepted on `reg_valid` only while `reg_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flag_evt | input | 4 | Single-cycle event pulses, bit order as in R3 |
| reg_valid | input | 1 | A register read result is offered |
| reg_addr | input | 4 | Address of the register read |
| reg_data | input | 8 | Contents of the register read |
| reg_ready | output | 1 | Result slot is free |
| rx_preempt | input | 1 | Receive operation takes over the bus |
| ctl_out | output | 2 | Control code: 00 idle, 01 status, 10 receive |
| dat_out | output | 2 | Two status bits per beat |

## Verification
Inputs are presented for one cycle. The following cycle is checked as still idle, and beat 0 is expected in the cycle after that. Each later beat is sampled exactly one cycle after the one before it, and the idle gap is checked in the cycle right after the final beat. The receive code is sampled in the same cycle that `rx_preempt` rises. Any retry is expected two cycles after `rx_preempt` falls, with its content computed from how many beats had already been driven. Every sample is taken shortly after a falling edge, so each result is read at one fixed cycle and never across a range of cycles.

// File: rtl/phy_stat_pkg.sv
package phy_stat_pkg;
  localparam int FLAG_W      = 4;
  localparam int ADDR_W      = 4;
  localparam int DATA_W      = 8;
  localparam int LANE_W      = 2;
  localparam int FRAME_W     = FLAG_W + ADDR_W + DATA_W;
  localparam int SHORT_BEATS = FLAG_W / LANE_W;
  localparam int LONG_BEATS  = FRAME_W / LANE_W;
  localparam int IDX_W       = $clog2(LONG_BEATS);

  typedef logic [1:0] ctl_t;
  localparam ctl_t CTL_IDLE = 2'b00;
  localparam ctl_t CTL_STAT = 2'b01;
  localparam ctl_t CTL_RECV = 2'b10;

  typedef enum logic [1:0] {SQ_IDLE, SQ_SEND, SQ_GAP} sq_state_t;

  // flags occupy the low bits; address then data follow, each MSB first
  function automatic logic [FRAME_W-1:0] pack_frame(
    input logic [FLAG_W-1:0] flags,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] data);
    logic [FRAME_W-1:0] f;
    for (int i = 0; i < FLAG_W; i++) f[i] = flags[i];
    for (int i = 0; i < ADDR_W; i++) f[FLAG_W+i] = addr[ADDR_W-1-i];
    for (int i = 0; i < DATA_W; i++) f[FLAG_W+ADDR_W+i] = data[DATA_W-1-i];
    return f;
  endfunction

  function automatic logic [LANE_W-1:0] beat_slice(
    input logic [FRAME_W-1:0] frame,
    input logic [IDX_W-1:0]   idx);
    logic [LANE_W-1:0] r;
    for (int l = 0; l < LANE_W; l++) r[l] = frame[int'(idx)*LANE_W + l];
    return r;
  endfunction
endpackage

// File: rtl/phy_stat_flags.sv
module phy_stat_flags
  import phy_stat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FLAG_W-1:0] evt,
  input  logic [FLAG_W-1:0] clr,
  output logic [FLAG_W-1:0] pend
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= '0;
    else        pend <= (pend & ~clr) | evt;
  end
endmodule

// File: rtl/phy_stat_regslot.sv
module phy_stat_regslot
  import phy_stat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  input  logic              done,
  output logic              pend,
  output logic              ready,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] data_q
);
  assign ready = !pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend   <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else if (!pend && valid) begin
      pend   <= 1'b1;
      addr_q <= addr;
      data_q <= data;
    end else if (done) begin
      pend   <= 1'b0;
    end
  end
endmodule

// File: rtl/phy_stat_seq.sv
module phy_stat_seq
  import phy_stat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FLAG_W-1:0] flags_pend,
  input  logic              reg_pend,
  input  logic [ADDR_W-1:0] reg_addr_q,
  input  logic [DATA_W-1:0] reg_data_q,
  input  logic              rx_preempt,
  output ctl_t              ctl_out,
  output logic [LANE_W-1:0] dat_out,
  output logic [FLAG_W-1:0] flag_clr,
  output logic              reg_done,
  output logic              beat_fire,
  output logic              last_beat,
  output logic              xfer_start,
  output logic              frame_long,
  output logic [IDX_W-1:0]  beat_idx
);
  sq_state_t          state;
  logic [IDX_W-1:0]   cnt;
  logic [FRAME_W-1:0] frame_q;
  logic               long_q;
  logic               has_work;

  assign has_work   = (|flags_pend) || reg_pend;
  assign beat_fire  = (state == SQ_SEND) && !rx_preempt;
  assign last_beat  = beat_fire &&
                      (cnt == (long_q ? IDX_W'(LONG_BEATS-1) : IDX_W'(SHORT_BEATS-1)));
  assign xfer_start = !rx_preempt && has_work && (state != SQ_SEND);
  assign reg_done   = last_beat && long_q;
  assign frame_long = long_q;
  assign beat_idx   = cnt;

  always_comb begin
    for (int i = 0; i < FLAG_W; i++)
      flag_clr[i] = beat_fire && (int'(cnt) == i / LANE_W) && frame_q[i];
  end

  always_comb begin
    if (rx_preempt) begin
      ctl_out = CTL_RECV;
      dat_out = '0;
    end else if (state == SQ_SEND) begin
      ctl_out = CTL_STAT;
      dat_out = beat_slice(frame_q, cnt);
    end else begin
      ctl_out = CTL_IDLE;
      dat_out = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= SQ_IDLE;
      cnt     <= '0;
      frame_q <= '0;
      long_q  <= 1'b0;
    end else begin
      case (state)
        SQ_SEND: begin
          if (rx_preempt || last_beat) state <= SQ_GAP;
          else                         cnt   <= cnt + 1'b1;
        end
        default: begin
          if (xfer_start) begin
            state   <= SQ_SEND;
            cnt     <= '0;
            long_q  <= reg_pend;
            frame_q <= pack_frame(flags_pend,
                                  reg_pend ? reg_addr_q : '0,
                                  reg_pend ? reg_data_q : '0);
          end else if (!rx_preempt) begin
            state <= SQ_IDLE;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/phy_status_tx.sv
module phy_status_tx
  import phy_stat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FLAG_W-1:0] flag_evt,
  input  logic              reg_valid,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_data,
  output logic              reg_ready,
  input  logic              rx_preempt,
  output logic [1:0]        ctl_out,
  output logic [LANE_W-1:0] dat_out
);
  logic [FLAG_W-1:0] flags_pend;
  logic [FLAG_W-1:0] flag_clr;
  logic              reg_pend;
  logic              reg_done;
  logic [ADDR_W-1:0] reg_addr_q;
  logic [DATA_W-1:0] reg_data_q;
  logic              beat_fire;
  logic              last_beat;
  logic              xfer_start;
  logic              frame_long;
  logic [IDX_W-1:0]  beat_idx;
  ctl_t              ctl_w;

  assign ctl_out = ctl_w;

  phy_stat_flags u_flags (
    .clk(clk), .rst_n(rst_n), .evt(flag_evt), .clr(flag_clr), .pend(flags_pend));

  phy_stat_regslot u_slot (
    .clk(clk), .rst_n(rst_n), .valid(reg_valid), .addr(reg_addr), .data(reg_data),
    .done(reg_done), .pend(reg_pend), .ready(reg_ready),
    .addr_q(reg_addr_q), .data_q(reg_data_q));

  phy_stat_seq u_seq (
    .clk(clk), .rst_n(rst_n), .flags_pend(flags_pend), .reg_pend(reg_pend),
    .reg_addr_q(reg_addr_q), .reg_data_q(reg_data_q), .rx_preempt(rx_preempt),
    .ctl_out(ctl_w), .dat_out(dat_out), .flag_clr(flag_clr), .reg_done(reg_done),
    .beat_fire(beat_fire), .last_beat(last_beat), .xfer_start(xfer_start),
    .frame_long(frame_long), .beat_idx(beat_idx));
endmodule

// File: rtl/phy_status_chk.sv
module phy_status_chk
  import phy_stat_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             rx_preempt,
  input logic [1:0]       ctl_out,
  input logic [1:0]       dat_out,
  input logic             reg_ready,
  input logic             beat_fire,
  input logic             last_beat,
  input logic             frame_long,
  input logic             reg_done,
  input logic [IDX_W-1:0] beat_idx
);
  a_r7_rx_owns_bus: assert property (@(posedge clk) disable iff (!rst_n)
    rx_preempt |-> (ctl_out == CTL_RECV && dat_out == 2'b00));

  a_r6_gap_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    last_beat |=> (ctl_out != CTL_STAT));

  a_r2_short_two_beats: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_fire && !frame_long && beat_idx == IDX_W'(1)) |=> (ctl_out != CTL_STAT));

  a_r3_long_only_beyond_two: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_fire && beat_idx >= IDX_W'(SHORT_BEATS)) |-> frame_long);

  a_r12_ready_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    reg_done |=> reg_ready);

  a_r12_busy_while_long: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_fire && frame_long) |-> !reg_ready);
endmodule

bind phy_status_tx phy_status_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rx_preempt(rx_preempt), .ctl_out(ctl_out),
  .dat_out(dat_out), .reg_ready(reg_ready), .beat_fire(beat_fire),
  .last_beat(last_beat), .frame_long(frame_long), .reg_done(reg_done),
  .beat_idx(beat_idx));

// File: tb/sim_phy_status_tx.sv
module sim_phy_status_tx;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 6;
  // {reg_valid, flags[3:0], addr[3:0], data[7:0]}
  localparam logic [16:0] VECS [NVEC] = '{
    {1'b0, 4'b0001, 4'h0, 8'h00},
    {1'b0, 4'b1010, 4'h0, 8'h00},
    {1'b0, 4'b1111, 4'h0, 8'h00},
    {1'b1, 4'b0000, 4'hA, 8'h5C},
    {1'b1, 4'b0110, 4'h3, 8'hF1},
    {1'b1, 4'b1001, 4'hF, 8'h80}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] flag_evt = '0;
  logic       reg_valid = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [7:0] reg_data = '0;
  logic       rx_preempt = 1'b0;
  logic       reg_ready;
  logic [1:0] ctl_out;
  logic [1:0] dat_out;
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  phy_status_tx u0 (
    .clk(clk), .rst_n(rst_n), .flag_evt(flag_evt), .reg_valid(reg_valid),
    .reg_addr(reg_addr), .reg_data(reg_data), .reg_ready(reg_ready),
    .rx_preempt(rx_preempt), .ctl_out(ctl_out), .dat_out(dat_out));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] mk_frame(input logic [3:0] f, input logic [3:0] a,
                                           input logic [7:0] d);
    logic [15:0] b;
    for (int i = 0; i < 4; i++) b[i] = f[i];
    for (int i = 0; i < 4; i++) b[4+i] = a[3-i];
    for (int i = 0; i < 8; i++) b[8+i] = d[7-i];
    return b;
  endfunction

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic expect_idle(input int n, input string req);
    for (int k = 0; k < n; k++) begin
      tick(); #2;
      check(ctl_out == 2'b00, req, ctl_out, 0);
    end
  endtask

  // beats start in the next cycle
  task automatic expect_frame(input logic [15:0] fr, input int nb, input string req);
    for (int j = 0; j < nb; j++) begin
      tick(); #2;
      check(ctl_out == 2'b01, {req, " ctl"}, ctl_out, 1);
      check(dat_out == {fr[2*j+1], fr[2*j]}, {req, " R4 data"}, dat_out,
            {fr[2*j+1], fr[2*j]});
    end
  endtask

  task automatic present(input logic [3:0] f, input bit v, input logic [3:0] a,
                         input logic [7:0] d);
    tick();
    flag_evt = f; reg_valid = v; reg_addr = a; reg_data = d;
    tick();
    flag_evt = '0; reg_valid = 1'b0;
    #2 check(ctl_out == 2'b00, "R5 latency idle", ctl_out, 0);
  endtask

  task automatic preempt_case(input logic [3:0] f, input bit v, input logic [3:0] a,
                              input logic [7:0] d, input int j);
    logic [3:0] rf;
    present(f, v, a, d);
    expect_frame(mk_frame(f, a, d), j, "R8 pre-beats");
    tick();
    rx_preempt = 1'b1;
    #2 check(ctl_out == 2'b10 && dat_out == 2'b00, "R7 receive code",
             {ctl_out, dat_out}, 4'b1000);
    tick();
    rx_preempt = 1'b0;
    #2 check(ctl_out == 2'b00, "R7 idle after receive", ctl_out, 0);
    if (v) check(reg_ready == 1'b0, "R12 held across preempt", reg_ready, 0);
    rf = (j >= 2) ? 4'b0000 : (j == 1) ? (f & 4'b1100) : f;
    if (rf == 4'b0000 && !v) begin
      expect_idle(4, "R10 no retry");
    end else begin
      expect_frame(v ? mk_frame(rf, a, d) : mk_frame(rf, 4'h0, 8'h00), v ? 8 : 2,
                   v ? "R9 full retry" : "R8 flag retry");
      expect_idle(2, "R6 gap after retry");
      if (v) check(reg_ready == 1'b1, "R12 ready after retry", reg_ready, 1);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 2 + 2);
    check(ctl_out == 2'b00 && dat_out == 2'b00, "R1 reset outputs", {ctl_out, dat_out}, 0);
    check(reg_ready == 1'b1, "R1 reset ready", reg_ready, 1);
    rst_n = 1'b1;
    expect_idle(3, "R1 stays idle");

    // table walk: plain transfers
    for (int n = 0; n < NVEC; n++) begin
      logic       v;
      logic [3:0] f, a;
      logic [7:0] d;
      {v, f, a, d} = VECS[n];
      present(f, v, a, d);
      if (v) begin
        tick(); #2;
        check(reg_ready == 1'b0, "R12 busy", reg_ready, 0);
        check(ctl_out == 2'b01 && dat_out == {mk_frame(f, a, d)[1], mk_frame(f, a, d)[0]},
              "R3 beat0", {ctl_out, dat_out}, {2'b01, mk_frame(f, a, d)[1:0]});
        for (int j = 1; j < 8; j++) begin
          tick(); #2;
          check(ctl_out == 2'b01 && dat_out == mk_frame(f, a, d)[2*j +: 2], "R3 long beat",
                {ctl_out, dat_out}, {2'b01, mk_frame(f, a, d)[2*j +: 2]});
        end
      end else begin
        expect_frame(mk_frame(f, 4'h0, 8'h00), 2, "R2 short");
      end
      tick(); #2;
      check(ctl_out == 2'b00, "R6 gap", ctl_out, 0);
      check(reg_ready == 1'b1, "R12 ready after", reg_ready, 1);
      expect_idle(2, "R10 nothing left");
    end

    // pre-emption at every beat of a flag plus register transfer
    for (int j = 0; j < 8; j++) preempt_case(4'b1111, 1'b1, 4'h6, 8'hA5, j);
    // pre-emption of flag-only transfers, including on the gap cycle
    for (int j = 0; j < 3; j++) preempt_case(4'b1011, 1'b0, 4'h0, 8'h00, j);

    // R11: event during a transfer goes out next, after one idle cycle
    present(4'b0001, 1'b1, 4'h2, 8'h3C);
    for (int j = 0; j < 8; j++) begin
      tick();
      flag_evt = (j == 3) ? 4'b1000 : 4'b0000;
      #2 check(dat_out == mk_frame(4'b0001, 4'h2, 8'h3C)[2*j +: 2], "R11 carrier beat",
               dat_out, mk_frame(4'b0001, 4'h2, 8'h3C)[2*j +: 2]);
    end
    tick(); #2;
    check(ctl_out == 2'b00, "R6 gap before queued", ctl_out, 0);
    expect_frame(mk_frame(4'b1000, 4'h0, 8'h00), 2, "R11 queued flags");
    expect_idle(2, "R11 done");

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule